// File: doc/BRIEF.md
# Shared-Bus Floating Read Model

This block predicts the byte that a processor or a video controller actually receives from a memory system in which the two masters take turns on a pair of buses and several address windows have no memory behind them. Each cycle one master presents an address, a read or write strobe, the data returned by the populated memories and the 4-bit colour-memory value that travels on the upper lines of the video bus. The block returns the byte that the requester would see, including the leftovers that appear when nothing drives the data lines.

Unpopulated reads do not return a fixed pattern. On a video-side hole the processor sees what the video controller fetched last. On a processor-side hole the processor sees its own last bus byte. The video controller, on a video-side hole, sees a byte chosen by where the processor's last access went, with its low nibble mixed with the residual colour nibble. A parameter picks whether that mixing is a bitwise AND or a bitwise OR. The result is registered and appears on `rdata` one clock after the access.

Top module: `flbus_float_read`

## Requirements
- R1: A synchronous active-high `rst` clears `rdata`, the last video byte, the last processor byte and the residual colour nibble to zero, and marks the processor's last access as processor-side. A video read of a video-side hole right after reset therefore returns 8'h00.
- R2: A read of a populated address (anything not listed in R3 to R5, and any video read outside the video area 16'h0000-16'h1FFF / 16'h8000-16'h9FFF) returns `mem_data` on `rdata` in the following cycle.
- R3: A processor read (`req_is_video`=0) of a video-side hole (16'h0400-16'h0FFF or 16'h9800-16'h9FFF) returns the last byte of the video controller, with no nibble mixing.
- R4: A processor read of colour memory (16'h9400-16'h97FF) returns `color_nyb` in bits 3:0 and bits 7:4 of the last video byte in bits 7:4.
- R5: A processor read of a processor-side hole (16'h2000-16'h7FFF or 16'hA000-16'hBFFF) returns the processor's own last bus byte; after fetching 8'h23 from populated memory, a read of 16'h2345 returns 8'h23.
- R6: A video read of a video-side hole, when the processor's last access was in the video area, returns the processor's last bus byte with its low nibble mixed with the residual colour nibble.
- R7: A video read of a video-side hole, when the processor's last access was processor-side, returns the video controller's own last byte with its low nibble mixed with the residual colour nibble; bits 7:4 pass unchanged.
- R8: With `LEAK_AND`=1 the mixing is AND, so a residual nibble of 4'hF leaves the byte intact; with `LEAK_AND`=0 it is OR, so 4'h0 leaves it intact.
- R9: The residual colour nibble is the `color_nyb` of the most recent access (by either master) inside the video area; processor-side accesses leave it unchanged, and a video hole read uses the value from before its own access.
- R10: A write (`wr_en`=1, priority over `rd_en`) leaves `rdata` unchanged and makes `wdata` the writer's last bus byte, so a later processor-side hole read returns it.
- R11: A cycle with neither `rd_en` nor `wr_en` leaves `rdata` and all history unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one bus access per cycle |
| rst | input | 1 | Synchronous active-high reset |
| req_is_video | input | 1 | 1 = video controller access, 0 = processor access |
| addr | input | 16 | Access address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe, wins over `rd_en` |
| wdata | input | 8 | Write data |
| mem_data | input | 8 | Data from populated memory for this address |
| color_nyb | input | 4 | Colour-memory nibble on the upper video data lines |
| rdata | output | 8 | Byte seen by the requester, one cycle after the access |

## Verification
The bound checker watches every cycle that populated reads return the memory byte, that processor reads of a video-side hole return the last video byte, that colour reads splice the nibble under the video byte's upper half, that the leak never sets (AND) or clears (OR) a bit against the residual nibble, and that writes and idle cycles hold the output and history. Which byte the video controller picks up as a function of the processor's last area, that processor-side accesses leave the residual nibble alone, and that written data later resurfaces on a hole read depend on multi-access histories, so only the bench's directed sequences and its random traffic against a bench model can show them, for both polarities side by side.

// File: rtl/flbus_pkg.sv
package flbus_pkg;

  typedef enum logic [1:0] {
    RG_POP   = 2'd0,
    RG_VOPEN = 2'd1,
    RG_COLOR = 2'd2,
    RG_COPEN = 2'd3
  } rgn_e;

  typedef struct packed {
    logic vbus;
    rgn_e kind;
  } rgn_t;

  function automatic logic in_rng(input logic [15:0] a,
                                  input logic [15:0] lo,
                                  input logic [15:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

endpackage

// File: rtl/flbus_decode.sv
module flbus_decode
  import flbus_pkg::*;
#(
  parameter logic [15:0] VB0_LO = 16'h0000,
  parameter logic [15:0] VB0_HI = 16'h1FFF,
  parameter logic [15:0] VB1_LO = 16'h8000,
  parameter logic [15:0] VB1_HI = 16'h9FFF,
  parameter logic [15:0] VH0_LO = 16'h0400,
  parameter logic [15:0] VH0_HI = 16'h0FFF,
  parameter logic [15:0] VH1_LO = 16'h9800,
  parameter logic [15:0] VH1_HI = 16'h9FFF,
  parameter logic [15:0] CM_LO  = 16'h9400,
  parameter logic [15:0] CM_HI  = 16'h97FF,
  parameter logic [15:0] CH0_LO = 16'h2000,
  parameter logic [15:0] CH0_HI = 16'h7FFF,
  parameter logic [15:0] CH1_LO = 16'hA000,
  parameter logic [15:0] CH1_HI = 16'hBFFF
) (
  input  logic [15:0] addr,
  output rgn_t        rgn
);

  logic hit_vbus, hit_vhole, hit_color, hit_chole;

  always_comb begin
    hit_vbus  = in_rng(addr, VB0_LO, VB0_HI) || in_rng(addr, VB1_LO, VB1_HI);
    hit_vhole = in_rng(addr, VH0_LO, VH0_HI) || in_rng(addr, VH1_LO, VH1_HI);
    hit_color = in_rng(addr, CM_LO, CM_HI);
    hit_chole = in_rng(addr, CH0_LO, CH0_HI) || in_rng(addr, CH1_LO, CH1_HI);

    rgn.vbus = hit_vbus;
    if (hit_vhole)      rgn.kind = RG_VOPEN;
    else if (hit_color) rgn.kind = RG_COLOR;
    else if (hit_chole) rgn.kind = RG_COPEN;
    else                rgn.kind = RG_POP;
  end

endmodule

// File: rtl/flbus_readmux.sv
module flbus_readmux
  import flbus_pkg::*;
#(
  parameter int DW       = 8,
  parameter int NW       = 4,
  parameter bit LEAK_AND = 1'b1
) (
  input  logic          is_video,
  input  rgn_e          kind,
  input  logic [DW-1:0] mem_data,
  input  logic [NW-1:0] color_nyb,
  input  logic [DW-1:0] vic_q,
  input  logic [DW-1:0] cpu_q,
  input  logic [NW-1:0] nyb_q,
  input  logic          prevv_q,
  output logic [DW-1:0] rd_val
);

  localparam int HW = DW - NW;

  logic [DW-1:0] leak_base;
  logic [NW-1:0] leak_low;

  assign leak_base = prevv_q ? cpu_q : vic_q;

  generate
    if (LEAK_AND) begin : g_and
      assign leak_low = leak_base[NW-1:0] & nyb_q;
    end else begin : g_or
      assign leak_low = leak_base[NW-1:0] | nyb_q;
    end
  endgenerate

  always_comb begin
    rd_val = mem_data;
    if (is_video) begin
      if (kind == RG_VOPEN) rd_val = {leak_base[DW-1:NW], leak_low};
    end else begin
      unique case (kind)
        RG_VOPEN: rd_val = vic_q;
        RG_COLOR: rd_val = {vic_q[DW-1:DW-HW], color_nyb};
        RG_COPEN: rd_val = cpu_q;
        default:  rd_val = mem_data;
      endcase
    end
  end

endmodule

// File: rtl/flbus_history.sv
module flbus_history #(
  parameter int DW = 8,
  parameter int NW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc,
  input  logic          is_video,
  input  logic          in_vbus,
  input  logic [DW-1:0] bus_byte,
  input  logic [NW-1:0] color_nyb,
  output logic [DW-1:0] vic_q,
  output logic [DW-1:0] cpu_q,
  output logic [NW-1:0] nyb_q,
  output logic          prevv_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      vic_q   <= '0;
      cpu_q   <= '0;
      nyb_q   <= '0;
      prevv_q <= 1'b0;
    end else if (acc) begin
      if (is_video) begin
        vic_q <= bus_byte;
      end else begin
        cpu_q   <= bus_byte;
        prevv_q <= in_vbus;
      end
      if (in_vbus) nyb_q <= color_nyb;
    end
  end

endmodule

// File: rtl/flbus_float_read.sv
module flbus_float_read
  import flbus_pkg::*;
#(
  parameter int DW       = 8,
  parameter int NW       = 4,
  parameter bit LEAK_AND = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_is_video,
  input  logic [15:0]   addr,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] mem_data,
  input  logic [NW-1:0] color_nyb,
  output logic [DW-1:0] rdata
);

  rgn_t          rgn;
  rgn_e          rg_kind;
  logic [DW-1:0] vic_q, cpu_q, rd_val, bus_byte;
  logic [NW-1:0] nyb_q;
  logic          prevv_q, acc, rd_only;

  assign rg_kind  = rgn.kind;
  assign acc      = rd_en | wr_en;
  assign rd_only  = rd_en & ~wr_en;
  assign bus_byte = wr_en ? wdata : rd_val;

  flbus_decode u_dec (
    .addr (addr),
    .rgn  (rgn)
  );

  flbus_readmux #(.DW(DW), .NW(NW), .LEAK_AND(LEAK_AND)) u_mux (
    .is_video  (req_is_video),
    .kind      (rg_kind),
    .mem_data  (mem_data),
    .color_nyb (color_nyb),
    .vic_q     (vic_q),
    .cpu_q     (cpu_q),
    .nyb_q     (nyb_q),
    .prevv_q   (prevv_q),
    .rd_val    (rd_val)
  );

  flbus_history #(.DW(DW), .NW(NW)) u_hist (
    .clk       (clk),
    .rst       (rst),
    .acc       (acc),
    .is_video  (req_is_video),
    .in_vbus   (rgn.vbus),
    .bus_byte  (bus_byte),
    .color_nyb (color_nyb),
    .vic_q     (vic_q),
    .cpu_q     (cpu_q),
    .nyb_q     (nyb_q),
    .prevv_q   (prevv_q)
  );

  always_ff @(posedge clk) begin
    if (rst)          rdata <= '0;
    else if (rd_only) rdata <= rd_val;
  end

endmodule

// File: rtl/flbus_float_read_chk.sv
module flbus_float_read_chk
  import flbus_pkg::*;
#(
  parameter int DW       = 8,
  parameter int NW       = 4,
  parameter bit LEAK_AND = 1'b1
) (
  input logic          clk,
  input logic          rst,
  input logic          req_is_video,
  input logic          rd_en,
  input logic          wr_en,
  input logic [DW-1:0] mem_data,
  input logic [NW-1:0] color_nyb,
  input logic [DW-1:0] rdata,
  input rgn_e          rg_kind,
  input logic [DW-1:0] vic_q,
  input logic [NW-1:0] nyb_q
);

  logic seen_q = 1'b0;
  always_ff @(posedge clk) seen_q <= 1'b1;

  logic rdo;
  assign rdo = rd_en && !wr_en;

  assert_reset_R1: assert property (@(posedge clk)
    seen_q && $past(rst) |-> rdata == '0);

  assert_pop_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(rdo) && $past(rg_kind) == RG_POP
    |-> rdata == $past(mem_data));

  assert_vhole_cpu_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(rdo) && !$past(req_is_video) && $past(rg_kind) == RG_VOPEN
    |-> rdata == $past(vic_q));

  assert_color_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(rdo) && !$past(req_is_video) && $past(rg_kind) == RG_COLOR
    |-> rdata[NW-1:0] == $past(color_nyb) && rdata[DW-1:NW] == $past(vic_q[DW-1:NW]));

  assert_leak_pol_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(rdo) && $past(req_is_video) && $past(rg_kind) == RG_VOPEN
    |-> (LEAK_AND ? ((rdata[NW-1:0] & ~$past(nyb_q)) == '0)
                  : ((~rdata[NW-1:0] & $past(nyb_q)) == '0)));

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !$past(rdo) |-> $stable(rdata));

  assert_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !$past(rd_en) && !$past(wr_en) |-> $stable(vic_q) && $stable(nyb_q));

endmodule

bind flbus_float_read flbus_float_read_chk #(.DW(DW), .NW(NW), .LEAK_AND(LEAK_AND)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_is_video (req_is_video),
  .rd_en        (rd_en),
  .wr_en        (wr_en),
  .mem_data     (mem_data),
  .color_nyb    (color_nyb),
  .rdata        (rdata),
  .rg_kind      (rg_kind),
  .vic_q        (vic_q),
  .nyb_q        (nyb_q)
);

// File: tb/sim_flbus_float_read.sv
module sim_flbus_float_read;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_is_video = 1'b0;
  logic [15:0] addr = '0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0]  wdata = '0, mem_data = '0;
  logic [3:0]  color_nyb = '0;
  logic [7:0]  rdata0, rdata1;

  int vectors = 0;
  int fails   = 0;
  string tag_ovr = "";

  // model state: index 0 = AND polarity (u0), 1 = OR polarity (u1)
  logic [7:0] m_vic [2];
  logic [7:0] m_cpu [2];
  logic [7:0] m_rd  [2];
  logic [3:0] m_nyb [2];
  logic       m_prevv [2];

  always #5 clk = ~clk;

  flbus_float_read #(.LEAK_AND(1'b1)) u0 (
    .clk(clk), .rst(rst), .req_is_video(req_is_video), .addr(addr),
    .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata), .mem_data(mem_data),
    .color_nyb(color_nyb), .rdata(rdata0));

  flbus_float_read #(.LEAK_AND(1'b0)) u1 (
    .clk(clk), .rst(rst), .req_is_video(req_is_video), .addr(addr),
    .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata), .mem_data(mem_data),
    .color_nyb(color_nyb), .rdata(rdata1));

  function automatic bit rng(input logic [15:0] a, input int lo, input int hi);
    return (int'(a) >= lo) && (int'(a) <= hi);
  endfunction
  function automatic bit f_vb(input logic [15:0] a);
    return rng(a, 'h0000, 'h1FFF) || rng(a, 'h8000, 'h9FFF);
  endfunction
  function automatic bit f_vh(input logic [15:0] a);
    return rng(a, 'h0400, 'h0FFF) || rng(a, 'h9800, 'h9FFF);
  endfunction
  function automatic bit f_cm(input logic [15:0] a);
    return rng(a, 'h9400, 'h97FF);
  endfunction
  function automatic bit f_ch(input logic [15:0] a);
    return rng(a, 'h2000, 'h7FFF) || rng(a, 'hA000, 'hBFFF);
  endfunction

  task automatic model_reset();
    for (int k = 0; k < 2; k++) begin
      m_vic[k] = '0; m_cpu[k] = '0; m_rd[k] = '0; m_nyb[k] = '0; m_prevv[k] = 1'b0;
    end
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: rdata=%02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  // one access; call at a negedge, returns at the next negedge after checking
  task automatic acc(input bit v, input logic [15:0] a, input bit r, input bit w,
                     input logic [7:0] wd, input logic [7:0] md, input logic [3:0] cn);
    string tg [2];
    req_is_video = v; addr = a; rd_en = r; wr_en = w;
    wdata = wd; mem_data = md; color_nyb = cn;
    for (int k = 0; k < 2; k++) begin
      logic [7:0] res, base, bus;
      if (v) begin
        if (f_vh(a)) begin
          base = m_prevv[k] ? m_cpu[k] : m_vic[k];
          res  = {base[7:4], (k == 0) ? (base[3:0] & m_nyb[k]) : (base[3:0] | m_nyb[k])};
          tg[k] = (k == 1) ? "R8" : (m_prevv[k] ? "R6" : "R7");
        end else begin
          res = md; tg[k] = "R2";
        end
      end else if (f_vh(a)) begin res = m_vic[k]; tg[k] = "R3"; end
      else if (f_cm(a)) begin res = {m_vic[k][7:4], cn}; tg[k] = "R4"; end
      else if (f_ch(a)) begin res = m_cpu[k]; tg[k] = "R5"; end
      else begin res = md; tg[k] = "R2"; end
      bus = w ? wd : res;
      if (r || w) begin
        if (v) m_vic[k] = bus;
        else begin m_cpu[k] = bus; m_prevv[k] = f_vb(a); end
        if (f_vb(a)) m_nyb[k] = cn;
      end
      if (r && !w) m_rd[k] = res;
      else tg[k] = w ? "R10" : "R11";
      if (tag_ovr != "") tg[k] = tag_ovr;
    end
    @(negedge clk);
    chk(tg[0], rdata0, m_rd[0]);
    chk(tg[1], rdata1, m_rd[1]);
  endtask

  task automatic do_reset(input int n);
    rst = 1'b1; rd_en = 1'b0; wr_en = 1'b0;
    repeat (n) @(negedge clk);
    rst = 1'b0;
    model_reset();
    chk("R1", rdata0, 8'h00);
    chk("R1", rdata1, 8'h00);
  endtask

  function automatic logic [15:0] pick_addr(input int sel);
    logic [15:0] a;
    case (sel)
      0: a = 16'h1000 + 16'($urandom % 'h1000);
      1: a = (($urandom % 2) == 0) ? 16'h0400 + 16'($urandom % 'h0C00)
                                   : 16'h9800 + 16'($urandom % 'h0800);
      2: a = 16'h9400 + 16'($urandom % 'h0400);
      3: a = (($urandom % 2) == 0) ? 16'h2000 + 16'($urandom % 'h6000)
                                   : 16'hA000 + 16'($urandom % 'h2000);
      4: a = 16'hC000 + 16'($urandom % 'h4000);
      default: a = 16'($urandom);
    endcase
    return a;
  endfunction

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: rdata=%02h expected completion", rdata0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
      end
    join_none

    void'($urandom(32'd20240611));
    @(negedge clk);
    do_reset(3);

    // R1: video hole read straight after reset sees cleared history
    tag_ovr = "R1";
    acc(1, 16'h0500, 1, 0, 8'h00, 8'hFF, 4'h3);
    chk("R1", rdata0, 8'h00);
    tag_ovr = "";

    // R2 then R5: operand byte 23 resurfaces on a processor-side hole
    acc(0, 16'hC000, 1, 0, 8'h00, 8'h23, 4'h0);
    chk("R2", rdata0, 8'h23);
    acc(0, 16'h2345, 1, 0, 8'h00, 8'h99, 4'h0);
    chk("R5", rdata0, 8'h23);

    // R7/R8: residual F stops the AND leak, OR sets the low bits
    acc(1, 16'h1000, 1, 0, 8'h00, 8'hC3, 4'hF);
    acc(0, 16'h3000, 1, 0, 8'h00, 8'h00, 4'h0);
    acc(1, 16'h0500, 1, 0, 8'h00, 8'h55, 4'h0);
    chk("R7", rdata0, 8'hC3);
    chk("R8", rdata1, 8'hCF);

    // R3 then R6: processor hole read, then video sees processor byte leaked
    acc(0, 16'h0600, 1, 0, 8'h00, 8'h11, 4'h4);
    chk("R3", rdata0, 8'hC3);
    acc(1, 16'h9900, 1, 0, 8'h00, 8'h22, 4'h0);
    chk("R6", rdata0, 8'hC0);
    chk("R8", rdata1, 8'hCF);

    // R4: colour read splices the nibble under the video byte
    acc(0, 16'h9400, 1, 0, 8'h00, 8'h00, 4'h9);
    chk("R4", rdata0, 8'hC9);

    // R9 and R10: processor-side write keeps residual nibble, holds rdata
    acc(1, 16'h0000, 1, 0, 8'h00, 8'h5A, 4'h2);
    acc(0, 16'h2000, 0, 1, 8'hE7, 8'h00, 4'hD);
    chk("R10", rdata0, 8'h5A);
    tag_ovr = "R9";
    acc(1, 16'h0400, 1, 0, 8'h00, 8'h00, 4'h0);
    chk("R9", rdata0, 8'h52);
    tag_ovr = "";
    acc(0, 16'h2FFF, 1, 0, 8'h00, 8'h00, 4'h0);
    chk("R10", rdata0, 8'hE7);

    // R11: idle cycles with busy-looking inputs change nothing
    acc(1, 16'h0400, 0, 0, 8'hFF, 8'hFF, 4'hF);
    acc(0, 16'h9400, 0, 0, 8'hFF, 8'hFF, 4'hF);
    chk("R11", rdata0, 8'hE7);
    acc(0, 16'h0700, 1, 0, 8'h00, 8'h00, 4'h0);
    chk("R11", rdata0, 8'h52);

    // random traffic, alternating masters
    for (int i = 0; i < 3000; i++) begin
      int  sel = int'($urandom % 6);
      int  op  = int'($urandom % 20);
      bit  v   = i[0];
      bit  w   = !v && (op < 3);
      bit  r   = !w && (op < 17);
      acc(v, pick_addr(sel), r, w, 8'($urandom), 8'($urandom), 4'($urandom));
    end

    // R1: reset in mid-traffic
    @(negedge clk);
    do_reset(2);
    tag_ovr = "R1";
    acc(1, 16'h9A00, 1, 0, 8'h00, 8'hAA, 4'h6);
    tag_ovr = "";

    for (int i = 0; i < 500; i++) begin
      int sel = int'($urandom % 6);
      acc(i[0], pick_addr(sel), 1'b1, 1'b0, 8'h00, 8'($urandom), 4'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule